// File: doc/BRIEF.md
# Timer Interrupt Enable and Pending Register

This block is the interrupt control word for a bank of countdown timer channels. A single 32-bit word carries one enable bit and one pending bit per channel. A write puts the enable bits in place directly. The same write also clears pending bits: each pending bit written with a one is cleared.

Each timer channel delivers a one-cycle expiry pulse. The pulse always marks its channel pending. It drives the channel's interrupt line high only if that channel was enabled when the pulse arrived. Each line is a registered level and stays high until software clears the matching pending bit. Changing the enable after an expiry has no effect on a pending bit or a line that is already set.

The block sits behind an address decoder. The decoder produces `wr_en` when software writes this word, and returns `rd_data` when software reads it.

Top module: `tmr_irq_csr`

## Requirements
- R1: After reset, `rd_data` is 0 and every `irq` line is low.
- R2: A write replaces the enable bits: channel n's enable is bit n, for n = 0..4. The new value is loaded from `wr_data[4:0]` and is visible on `rd_data[4:0]` in the cycle after the write.
- R3: Writing a 1 to pending bit 5+n clears it in the cycle after the write. Writing a 0 to that bit leaves it unchanged.
- R4: An expiry pulse on channel n sets pending bit 5+n in the next cycle, whether or not the channel is enabled.
- R5: If an expiry and a write-one-to-clear hit the same pending bit in the same cycle, the bit ends up set.
- R6: An expiry on channel n raises `irq[n]` in the next cycle if enable bit n read as 1 in the cycle of the expiry. This holds even when a write in that same cycle clears the enable.
- R7: An expiry on a disabled channel leaves `irq[n]` low. Enabling the channel afterwards does not raise the line.
- R8: `irq[n]` stays high until pending bit 5+n is cleared, and it falls in the same cycle as that bit. Clearing the enable does not lower the line.
- R9: Bits 31:10 of `rd_data` always read 0, and writes to those bits have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for this word |
| wr_data | input | 32 | Write data: enables in [4:0], clear mask in [9:5] |
| expire | input | 5 | One-cycle expiry pulse per channel |
| rd_data | output | 32 | Current word: enables in [4:0], pending in [9:5] |
| irq | output | 5 | Level interrupt line per channel |

## Verification
The bench drives an expiry and a clear of the same bit in one cycle. A design that gives the clear priority would lose that event and drop its line. It writes a new enable value in the same cycle as expiries. A design that looks at the enable value being written, instead of the one in force, would hold back a line that should rise. It also enables a channel that is already pending and then disables a channel whose line is high. A design that derives the line from enable AND pending would raise a line it should not in the first case and drop a live line in the second. Finally it writes all ones to the unused upper bits and checks that they still read zero.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
   localparam int unsigned CH_DEF   = 5;
   localparam int unsigned WORD_DEF = 32;

   function automatic int unsigned pend_base(int unsigned en_lsb, int unsigned nch);
      return en_lsb + nch;
   endfunction
endpackage

// File: rtl/tmr_irq_en_field.sv
module tmr_irq_en_field #(
   parameter int unsigned NCH = 5
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic [NCH-1:0] wr_bits,
   output logic [NCH-1:0] en_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (wr_en) begin
         en_q <= wr_bits;
      end
   end
endmodule

// File: rtl/tmr_irq_chan.sv
module tmr_irq_chan (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_req,
   input  logic expire,
   input  logic en_now,
   output logic pend_q,
   output logic line_q
);
   logic pend_d;
   logic line_d;

   always_comb begin
      if (expire) begin
         pend_d = 1'b1;
      end else if (clr_req) begin
         pend_d = 1'b0;
      end else begin
         pend_d = pend_q;
      end
   end

   always_comb begin
      if (expire && en_now) begin
         line_d = 1'b1;
      end else if (pend_q && !pend_d) begin
         line_d = 1'b0;
      end else begin
         line_d = line_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         line_q <= 1'b0;
      end else begin
         pend_q <= pend_d;
         line_q <= line_d;
      end
   end
endmodule

// File: rtl/tmr_irq_rdmux.sv
module tmr_irq_rdmux #(
   parameter int unsigned NCH    = 5,
   parameter int unsigned DW     = 32,
   parameter int unsigned EN_LSB = 0,
   parameter int unsigned ST_LSB = 5
) (
   input  logic [NCH-1:0] en_q,
   input  logic [NCH-1:0] pend_q,
   output logic [DW-1:0]  word
);
   always_comb begin
      word = '0;
      for (int i = 0; i < int'(NCH); i++) begin
         word[EN_LSB + i] = en_q[i];
         word[ST_LSB + i] = pend_q[i];
      end
   end
endmodule

// File: rtl/tmr_irq_csr.sv
module tmr_irq_csr
   import tmr_irq_pkg::*;
#(
   parameter int unsigned NCH    = CH_DEF,
   parameter int unsigned DW     = WORD_DEF,
   parameter int unsigned EN_LSB = 0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic [DW-1:0]  wr_data,
   input  logic [NCH-1:0] expire,
   output logic [DW-1:0]  rd_data,
   output logic [NCH-1:0] irq
);
   localparam int unsigned ST_LSB = pend_base(EN_LSB, NCH);
   localparam int unsigned TOP_HI = ST_LSB + NCH;

   generate
      if (TOP_HI > DW) begin : g_bad_width
         $error("tmr_irq_csr: fields do not fit in the word");
      end
      if (NCH < 1) begin : g_bad_count
         $error("tmr_irq_csr: need at least one channel");
      end
   endgenerate

   logic [NCH-1:0] en_q;
   logic [NCH-1:0] pend_q;

   tmr_irq_en_field #(.NCH(NCH)) u_en (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_bits (wr_data[EN_LSB +: NCH]),
      .en_q    (en_q)
   );

   genvar gi;
   generate
      for (gi = 0; gi < int'(NCH); gi++) begin : g_ch
         tmr_irq_chan u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr_req (wr_en && wr_data[ST_LSB + gi]),
            .expire  (expire[gi]),
            .en_now  (en_q[gi]),
            .pend_q  (pend_q[gi]),
            .line_q  (irq[gi])
         );
      end
   endgenerate

   tmr_irq_rdmux #(
      .NCH(NCH), .DW(DW), .EN_LSB(EN_LSB), .ST_LSB(ST_LSB)
   ) u_rd (
      .en_q   (en_q),
      .pend_q (pend_q),
      .word   (rd_data)
   );
endmodule

// File: rtl/tmr_irq_csr_chk.sv
module tmr_irq_csr_chk #(
   parameter int unsigned NCH    = 5,
   parameter int unsigned DW     = 32,
   parameter int unsigned EN_LSB = 0
) (
   input logic           clk,
   input logic           rst_n,
   input logic           wr_en,
   input logic [DW-1:0]  wr_data,
   input logic [NCH-1:0] expire,
   input logic [DW-1:0]  rd_data,
   input logic [NCH-1:0] irq
);
   localparam int unsigned ST_LSB = EN_LSB + NCH;
   localparam int unsigned TOP_HI = ST_LSB + NCH;

   a_r2_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> rd_data[EN_LSB +: NCH] == $past(wr_data[EN_LSB +: NCH]));

   generate
      if (TOP_HI < DW) begin : g_hi
         a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
            rd_data[DW-1:TOP_HI] == '0);
         a_r9_upper_ignored: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (|wr_data[DW-1:TOP_HI])) |=> rd_data[DW-1:TOP_HI] == '0);
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < int'(NCH); gi++) begin : g_ch
         a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_data[ST_LSB+gi] && wr_en && wr_data[ST_LSB+gi] && !expire[gi])
            |=> !rd_data[ST_LSB+gi]);
         a_r3_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_data[ST_LSB+gi] && !(wr_en && wr_data[ST_LSB+gi])) |=> rd_data[ST_LSB+gi]);
         a_r4_r5_set: assert property (@(posedge clk) disable iff (!rst_n)
            expire[gi] |=> rd_data[ST_LSB+gi]);
         a_r6_raise: assert property (@(posedge clk) disable iff (!rst_n)
            (expire[gi] && rd_data[EN_LSB+gi]) |=> irq[gi]);
         a_r7_no_raise: assert property (@(posedge clk) disable iff (!rst_n)
            (!irq[gi] && !(expire[gi] && rd_data[EN_LSB+gi])) |=> !irq[gi]);
         a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (irq[gi] && !(wr_en && wr_data[ST_LSB+gi] && !expire[gi])) |=> irq[gi]);
         a_r8_fall_with_pend: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(rd_data[ST_LSB+gi]) |-> !irq[gi]);
         a_r8_line_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
            irq[gi] |-> rd_data[ST_LSB+gi]);
      end
   endgenerate
endmodule

bind tmr_irq_csr tmr_irq_csr_chk #(.NCH(NCH), .DW(DW), .EN_LSB(EN_LSB)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_data (wr_data),
   .expire  (expire),
   .rd_data (rd_data),
   .irq     (irq)
);

// File: tb/tmr_irq_csr_tb.sv
module tmr_irq_csr_tb;
   localparam int NCH = 5;
   localparam int DW  = 32;
   localparam int NV  = 12;

   logic           clk = 1'b0;
   logic           rst_n;
   logic           wr_en;
   logic [DW-1:0]  wr_data;
   logic [NCH-1:0] expire;
   logic [DW-1:0]  rd_data;
   logic [NCH-1:0] irq;

   int n_cmp = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   tmr_irq_csr u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .expire(expire), .rd_data(rd_data), .irq(irq)
   );

   // {wr, wdata[9:0], expire, expected rd[9:0], expected irq}
   localparam logic [30:0] VEC [NV] = '{
      {1'b1, 10'h01F, 5'b00000, 10'h01F, 5'b00000},
      {1'b0, 10'h000, 5'b00001, 10'h03F, 5'b00001},
      {1'b1, 10'h000, 5'b00000, 10'h020, 5'b00001},
      {1'b0, 10'h000, 5'b00010, 10'h060, 5'b00001},
      {1'b1, 10'h01F, 5'b00000, 10'h07F, 5'b00001},
      {1'b1, 10'h05F, 5'b00000, 10'h03F, 5'b00001},
      {1'b1, 10'h03F, 5'b00001, 10'h03F, 5'b00001},
      {1'b1, 10'h03F, 5'b00000, 10'h01F, 5'b00000},
      {1'b1, 10'h00C, 5'b11100, 10'h38C, 5'b11100},
      {1'b1, 10'h30C, 5'b00000, 10'h08C, 5'b00100},
      {1'b0, 10'h000, 5'b00010, 10'h0CC, 5'b00100},
      {1'b1, 10'h3E0, 5'b00000, 10'h000, 5'b00000}
   };

   function automatic string vec_tag(int i);
      case (i)
         0: return "R2";
         1: return "R4";
         2: return "R8";
         3: return "R7";
         4: return "R7";
         5: return "R3";
         6: return "R5";
         7: return "R8";
         8: return "R6";
         9: return "R3";
         10: return "R4";
         default: return "R3";
      endcase
   endfunction

   task automatic check(string tag, logic [DW-1:0] exp_rd, logic [NCH-1:0] exp_irq);
      n_cmp++;
      if (rd_data !== exp_rd || irq !== exp_irq) begin
         n_bad++;
         $display("FAIL %s: rd_data=%h irq=%b expected rd_data=%h irq=%b",
                  tag, rd_data, irq, exp_rd, exp_irq);
      end
   endtask

   task automatic drive(logic w, logic [DW-1:0] d, logic [NCH-1:0] e);
      wr_en   = w;
      wr_data = d;
      expire  = e;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      drive(1'b0, '0, '0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      rst_n = 1'b0;
      drive(1'b0, '0, '0);
      @(negedge clk);
      do_reset();
      check("R1", '0, '0);

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i][30], {22'b0, VEC[i][29:20]}, VEC[i][19:15]);
         @(negedge clk);
         check(vec_tag(i), {22'b0, VEC[i][14:5]}, VEC[i][4:0]);
      end
      drive(1'b0, '0, '0);

      // R9: upper bits written all ones; only the enable bits take effect
      drive(1'b1, 32'hFFFF_FC03, '0);
      @(negedge clk);
      check("R9", 32'h0000_0003, '0);
      drive(1'b0, '0, '0);
      @(negedge clk);
      check("R9", 32'h0000_0003, '0);

      // R8: disabling a channel whose line is high keeps the line
      drive(1'b0, '0, 5'b00001);
      @(negedge clk);
      check("R8", 32'h0000_0023, 5'b00001);
      drive(1'b1, 32'h0000_0000, '0);
      @(negedge clk);
      check("R8", 32'h0000_0020, 5'b00001);

      // R1: reset mid-run clears everything
      do_reset();
      check("R1", '0, '0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #1_000_000;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule